// File: doc/BRIEF.md
# Lane-Split Add/Subtract and Bitwise Logic Unit

This unit takes two 48-bit operands and produces a registered 48-bit result. In arithmetic operation it adds or subtracts. The 48 bits can be treated as a single lane, as two separate 24-bit lanes, or as four separate 12-bit lanes. Every lane wraps modulo two to the power of its own width, and every lane reports its own carry-out. When accumulation is enabled, the unit feeds its own registered result back in place of the first operand. This lets it act as a running per-lane adder or a running per-lane subtractor.

A separate logic operation applies one of ten bitwise functions to the two operands, selected by a 4-bit code. No multiplier is involved. Operands go straight into the adder or into the logic unit. A synchronous clear empties the result register on any cycle.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `result` and `carry_out` are zero.
- R2: With `mode`=0, `result` is (A op B) mod 2^48 on the rising edge after the inputs are presented. In this mode `op`=0 adds and `op`=1 subtracts.
- R3: With `mode`=1 there are two 24-bit lanes, on bits [23:0] and [47:24]. Each lane wraps on its own, and no carry or borrow crosses bit 24.
- R4: With `mode`=2 or `mode`=3 there are four 12-bit lanes, on bits [11:0], [23:12], [35:24] and [47:36]. No carry or borrow crosses a lane boundary.
- R5: Subtract computes A + ~B + 1 in each lane. The lane carry-out is 1 exactly when the lane's unsigned A is greater than or equal to its unsigned B.
- R6: `carry_out[i]` is the carry of lane i, with lane 0 in the lowest bits. Bits [3:1] are zero in one-lane mode, and bits [3:2] are zero in two-lane mode.
- R7: When `acc_en` is 1 and `op` is add or subtract, the registered `result` replaces A in every lane.
- R8: When `op` is 2 or 3, `result` is a bitwise function of A and B, and `carry_out` is zero. The function codes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 A AND NOT B, 7 A OR NOT B, 8 NOT A, and 9 pass A. Codes 10 to 15 give zero. In this mode `acc_en` has no effect.
- R9: If `clr` is 1 at a rising edge, `result` and `carry_out` become zero, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the result register |
| mode | input | 2 | Lane split: 0 one lane, 1 two lanes, 2 or 3 four lanes |
| op | input | 2 | 0 add, 1 subtract, 2 or 3 logic |
| acc_en | input | 1 | Use the registered result as the first operand |
| logic_sel | input | 4 | Bitwise function code |
| opnd_a | input | 48 | First operand |
| opnd_b | input | 48 | Second operand |
| result | output | 48 | Registered result |
| carry_out | output | 4 | Registered per-lane carry-out |

## Verification
Each lane mode is first driven with all-ones plus one and with zero minus one. These operands carry or borrow through every bit of every lane, so a carry leaking across a split boundary shows up at once. Pseudo-random operands are then run under each combination of mode and operation, which separates wrong lane extraction from wrong carry mapping. Accumulation runs as chains of repeated adds and subtracts that start from a clear, so the feedback path and the lane wrap are tested together. All sixteen logic codes are applied to four operand patterns with `acc_en` toggling, which shows that each code selects its own function and that accumulation has no effect in logic mode.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int NUM_SEG = 4;

    typedef enum logic [1:0] {
        LANE_X1  = 2'd0,
        LANE_X2  = 2'd1,
        LANE_X4  = 2'd2,
        LANE_X4B = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_SUB    = 2'd1,
        OP_LOGIC  = 2'd2,
        OP_LOGICB = 2'd3
    } alu_op_e;

    typedef enum logic [3:0] {
        LF_AND   = 4'd0,
        LF_OR    = 4'd1,
        LF_XOR   = 4'd2,
        LF_NAND  = 4'd3,
        LF_NOR   = 4'd4,
        LF_XNOR  = 4'd5,
        LF_ANDNB = 4'd6,
        LF_ORNB  = 4'd7,
        LF_NOTA  = 4'd8,
        LF_PASSA = 4'd9
    } logic_fn_e;

    // A segment starts a new lane when its carry-in must be cut.
    function automatic logic seg_starts_lane(input lane_mode_e m, input int k);
        logic four;
        four = (m == LANE_X4) || (m == LANE_X4B);
        return (k == 0) || (k == 2 && m != LANE_X1) || ((k % 2) == 1 && four);
    endfunction

    function automatic logic is_arith(input alu_op_e o);
        return (o == OP_ADD) || (o == OP_SUB);
    endfunction

endpackage

// File: rtl/simd_alu_addsub.sv
module simd_alu_addsub
    import simd_alu_pkg::*;
#(
    parameter int SEG_W = 12,
    localparam int DATA_W = SEG_W * NUM_SEG
) (
    input  lane_mode_e          mode,
    input  logic                sub,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   sum,
    output logic [NUM_SEG-1:0]  seg_co
);

    logic [DATA_W-1:0] b_eff;
    assign b_eff = sub ? ~b : b;

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        logic             cin;
        logic [SEG_W:0]   part;
        if (k == 0) begin : g_first
            assign cin = sub;
        end else begin : g_rest
            assign cin = seg_starts_lane(mode, k) ? sub : seg_co[k-1];
        end
        assign part = {1'b0, a[k*SEG_W +: SEG_W]}
                    + {1'b0, b_eff[k*SEG_W +: SEG_W]}
                    + {{SEG_W{1'b0}}, cin};
        assign sum[k*SEG_W +: SEG_W] = part[SEG_W-1:0];
        assign seg_co[k]             = part[SEG_W];
    end

endmodule

// File: rtl/simd_alu_logic.sv
module simd_alu_logic
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 48
) (
    input  logic [3:0]         fn,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);

    always_comb begin
        case (fn)
            LF_AND:   y = a & b;
            LF_OR:    y = a | b;
            LF_XOR:   y = a ^ b;
            LF_NAND:  y = ~(a & b);
            LF_NOR:   y = ~(a | b);
            LF_XNOR:  y = ~(a ^ b);
            LF_ANDNB: y = a & ~b;
            LF_ORNB:  y = a | ~b;
            LF_NOTA:  y = ~a;
            LF_PASSA: y = a;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int SEG_W = 12,
    localparam int DATA_W = SEG_W * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [1:0]         mode,
    input  logic [1:0]         op,
    input  logic               acc_en,
    input  logic [3:0]         logic_sel,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic [DATA_W-1:0]  result,
    output logic [NUM_SEG-1:0] carry_out
);

    lane_mode_e         mode_e;
    alu_op_e            op_e;
    logic [DATA_W-1:0]  a_sel;
    logic [DATA_W-1:0]  arith_sum;
    logic [DATA_W-1:0]  logic_y;
    logic [NUM_SEG-1:0] seg_co;
    logic [NUM_SEG-1:0] lane_co;

    assign mode_e = lane_mode_e'(mode);
    assign op_e   = alu_op_e'(op);
    assign a_sel  = (acc_en && is_arith(op_e)) ? result : opnd_a;

    simd_alu_addsub #(.SEG_W(SEG_W)) addsub_i (
        .mode   (mode_e),
        .sub    (op_e == OP_SUB),
        .a      (a_sel),
        .b      (opnd_b),
        .sum    (arith_sum),
        .seg_co (seg_co)
    );

    simd_alu_logic #(.DATA_W(DATA_W)) logic_i (
        .fn (logic_sel),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    always_comb begin
        case (mode_e)
            LANE_X1: lane_co = {3'b000, seg_co[3]};
            LANE_X2: lane_co = {2'b00, seg_co[3], seg_co[1]};
            default: lane_co = seg_co;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            result    <= '0;
            carry_out <= '0;
        end else if (is_arith(op_e)) begin
            result    <= arith_sum;
            carry_out <= lane_co;
        end else begin
            result    <= logic_y;
            carry_out <= '0;
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (result == '0 && carry_out == '0));

    // R6
    one_lane_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> (carry_out[3:1] == 3'b000));

    // R6
    two_lane_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> (carry_out[3:2] == 2'b00));

    // R8
    logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op[1] == 1'b1) |=> (carry_out == '0));

    // R8
    pass_a_chk: assert property (@(posedge clk) disable iff (rst)
        (op[1] && logic_sel == 4'd9 && !clr) |=> (result == $past(opnd_a)));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && op == 2'd0 && opnd_b == '0 && !clr)
        |=> (result == $past(result) && carry_out == '0));

endmodule

// File: tb/simd_alu_tb_top.sv
module simd_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  op = 2'd0;
    logic        acc_en = 1'b0;
    logic [3:0]  logic_sel = 4'd0;
    logic [47:0] opnd_a = '0;
    logic [47:0] opnd_b = '0;
    logic [47:0] result;
    logic [3:0]  carry_out;

    int checks = 0;
    int errors = 0;
    logic [47:0] exp_q = '0;
    longint unsigned seed = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    simd_alu dut_i (
        .clk(clk), .rst(rst), .clr(clr), .mode(mode), .op(op),
        .acc_en(acc_en), .logic_sel(logic_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .result(result), .carry_out(carry_out)
    );

    function automatic logic [47:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed[47:0];
    endfunction

    task automatic model(input logic [47:0] a, b, input logic [1:0] m, o,
                         input logic acc, input logic [3:0] fn, input logic c,
                         output logic [47:0] er, output logic [3:0] ec);
        int w;
        int n;
        longint unsigned mask, x, y, s, src;
        er = '0;
        ec = '0;
        if (c) return;
        if (o >= 2) begin
            case (fn)
                4'd0: er = a & b;
                4'd1: er = a | b;
                4'd2: er = a ^ b;
                4'd3: er = ~(a & b);
                4'd4: er = ~(a | b);
                4'd5: er = ~(a ^ b);
                4'd6: er = a & ~b;
                4'd7: er = a | ~b;
                4'd8: er = ~a;
                4'd9: er = a;
                default: er = '0;
            endcase
            return;
        end
        w = (m == 2'd0) ? 48 : (m == 2'd1) ? 24 : 12;
        n = 48 / w;
        mask = (64'd1 << w) - 1;
        src = acc ? {16'd0, exp_q} : {16'd0, a};
        for (int i = 0; i < n; i++) begin
            x = (src >> (i * w)) & mask;
            y = ({16'd0, b} >> (i * w)) & mask;
            s = (o == 2'd1) ? x + ((~y) & mask) + 1 : x + y;
            er = er | 48'((s & mask) << (i * w));
            ec[i] = s[w];
        end
    endtask

    task automatic apply(input logic [47:0] a, b, input logic [1:0] m, o,
                         input logic acc, input logic [3:0] fn, input logic c,
                         input string tag);
        logic [47:0] er;
        logic [3:0]  ec;
        model(a, b, m, o, acc, fn, c, er, ec);
        opnd_a = a; opnd_b = b; mode = m; op = o;
        acc_en = acc; logic_sel = fn; clr = c;
        @(posedge clk);
        #2;
        checks++;
        if (result !== er || carry_out !== ec) begin
            errors++;
            $display("FAIL %s: mode=%0d op=%0d fn=%0d result=%h carry=%b expected result=%h carry=%b",
                     tag, m, o, fn, result, carry_out, er, ec);
        end
        exp_q = er;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (result !== '0 || carry_out !== '0) begin
            errors++;
            $display("FAIL R1: result=%h carry=%b expected 0 0", result, carry_out);
        end
        rst = 1'b0;
        @(posedge clk);
        #2;
        checks++;
        if (result !== '0 || carry_out !== '0) begin
            errors++;
            $display("FAIL R1: result=%h carry=%b expected 0 0 after release", result, carry_out);
        end

        // Full carry and full borrow ripple in each mode: R2 R3 R4 R5 R6
        for (int m = 0; m < 4; m++) begin
            apply({48{1'b1}}, 48'h000001_000001, 2'(m), 2'd0, 1'b0, 4'd0, 1'b0, "R3 R4 R6 carry ripple");
            apply({4{12'h001}}, {48{1'b1}} >> 0, 2'(m), 2'd0, 1'b0, 4'd0, 1'b0, "R2 R6 all-ones add");
            apply('0, {4{12'h001}}, 2'(m), 2'd1, 1'b0, 4'd0, 1'b0, "R5 borrow ripple");
            apply({4{12'h800}}, {4{12'h800}}, 2'(m), 2'd1, 1'b0, 4'd0, 1'b0, "R5 equal operands");
        end

        // Random operands in every mode and arithmetic op: R2 R3 R4 R5
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 2; o++)
                for (int k = 0; k < 40; k++)
                    apply(rnd(), rnd(), 2'(m), 2'(o), 1'b0, 4'd0, 1'b0, "R2 R3 R4 R5 random");

        // Accumulate chains: R7 R9
        for (int m = 0; m < 3; m++)
            for (int o = 0; o < 2; o++) begin
                apply(rnd(), rnd(), 2'(m), 2'(o), 1'b1, 4'd0, 1'b1, "R9 clear before accumulate");
                for (int k = 0; k < 20; k++)
                    apply(rnd(), rnd() >> 2, 2'(m), 2'(o), 1'b1, 4'd0, 1'b0, "R7 accumulate");
                apply(rnd(), 48'd0, 2'(m), 2'd0, 1'b1, 4'd0, 1'b0, "R7 accumulate zero holds");
            end

        // Logic codes, all sixteen, acc_en toggled: R8
        for (int fn = 0; fn < 16; fn++) begin
            apply(48'hF0F0F0_F0F0F0, 48'hFF00FF_00FF00, 2'd0, 2'd2, 1'(fn % 2), 4'(fn), 1'b0, "R8 logic pattern");
            apply(rnd(), rnd(), 2'd1, 2'd3, 1'b1, 4'(fn), 1'b0, "R8 logic random acc ignored");
            apply('0, {48{1'b1}}, 2'd2, 2'd2, 1'b0, 4'(fn), 1'b0, "R8 logic zero/ones");
            apply({48{1'b1}}, '0, 2'd3, 2'd3, 1'b1, 4'(fn), 1'b0, "R8 logic ones/zero");
        end

        // Clear wins over any operation: R9
        apply({48{1'b1}}, 48'd1, 2'd0, 2'd0, 1'b0, 4'd0, 1'b0, "R2 setup");
        apply({48{1'b1}}, 48'd1, 2'd2, 2'd0, 1'b1, 4'd0, 1'b1, "R9 clear over add");
        apply(rnd(), rnd(), 2'd1, 2'd2, 1'b0, 4'd9, 1'b1, "R9 clear over logic");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule